// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the six bytes of the destination address, whether a frame is kept. Bytes arrive one per cycle while `in_valid` is high. `in_sof` marks the first byte of a frame and `in_eof` marks its last byte. The decision arrives as a single-cycle strobe on `dec_valid`, and `dec_accept` qualifies it.

The block tests its checks in a fixed priority. Promiscuous mode comes first, then an exact compare against the station address, then the broadcast address. When none of these match and hashing is enabled, the last check is a 64-bin multicast hash table indexed by CRC bits. Configuration is static. It comes from a receive enable, a promiscuous bit, a hash enable, three 16-bit station address words and four 16-bit hash words. The block samples it in the cycle the decision is formed.

Top module: `rx_addr_filter`

## Requirements
- R1: While `cfg_rx_en` is low in the cycle a decision would be formed, no strobe is issued for that frame.
- R2: With `cfg_promisc` high, a frame of at least six bytes is accepted whatever its destination.
- R3: Exact match maps byte 0 (first on the wire) to `sta_w0[15:8]`, byte 1 to `sta_w0[7:0]`, byte 2 to `sta_w1[15:8]`, byte 3 to `sta_w1[7:0]`, byte 4 to `sta_w2[15:8]`, byte 5 to `sta_w2[7:0]`. A full match accepts the frame.
- R4: A destination whose six bytes are all 0xFF is accepted as broadcast.
- R5: With `cfg_hash_en` high and no exact or broadcast match, the block computes a CRC over the six bytes. The CRC starts at 0xFFFFFFFF, processes each byte LSB first with the reflected polynomial 0xEDB88320, and is not inverted. Bits 31:26 of the result form the index. Index bits 5:4 equal to k select `hash_wk`, and index bits 3:0 select the bit in that word. A set bit accepts the frame and a clear bit rejects it.
- R6: With no exact or broadcast match and `cfg_hash_en` low, the frame is rejected, even when the hash table is all ones.
- R7: For each frame the block issues exactly one strobe, one cycle wide. The strobe appears in the cycle after the sixth byte is taken, and bytes after the sixth do not change it.
- R8: A frame whose `in_eof` arrives before its sixth byte gets one reject strobe in the cycle after that byte, in every mode including promiscuous.
- R9: When `in_eof` falls on the sixth byte itself, the block issues the full address decision, not a short-frame reject.
- R10: After reset `dec_valid` is low and no frame is in progress, so bytes without a preceding `in_sof` produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_hash_en | input | 1 | Use the multicast hash table |
| sta_w0 | input | 16 | Station address bytes 0 and 1 |
| sta_w1 | input | 16 | Station address bytes 2 and 3 |
| sta_w2 | input | 16 | Station address bytes 4 and 5 |
| hash_w0 | input | 16 | Hash bins 0 to 15 |
| hash_w1 | input | 16 | Hash bins 16 to 31 |
| hash_w2 | input | 16 | Hash bins 32 to 47 |
| hash_w3 | input | 16 | Hash bins 48 to 63 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted, qualified by `dec_valid` |

## Verification
Two functions can fire on the same byte: completion of the address decision and the short-frame end. This happens when a frame's `in_eof` falls on its sixth byte. The bench sends an exactly six-byte frame addressed to the station and checks two things: only one strobe appears, and it carries the accept from the exact compare, not the short-frame reject. The same test also checks that a strobe on the cycle right after the sixth byte is the only one seen, with a one-byte and a three-byte frame as contrast.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        cfg_rx_en,
  input  logic        cfg_promisc,
  input  logic        cfg_hash_en,
  input  logic [15:0] sta_w0,
  input  logic [15:0] sta_w1,
  input  logic [15:0] sta_w2,
  input  logic [15:0] hash_w0,
  input  logic [15:0] hash_w1,
  input  logic [15:0] hash_w2,
  input  logic [15:0] hash_w3,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(ADDR_BYTES - 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic          active_q, ex_q, bc_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   crc_q;

  wire [47:0]   sta_all  = {sta_w0, sta_w1, sta_w2};
  wire [63:0]   hash_all = {hash_w3, hash_w2, hash_w1, hash_w0};

  wire          take     = in_valid & (in_sof | active_q);
  wire [CW-1:0] idx      = in_sof ? '0 : cnt_q;
  wire [7:0]    exp_byte = sta_all[6'd47 - {idx[2:0], 3'b000} -: 8];
  wire          ex_n     = (in_sof | ex_q) & (in_data == exp_byte);
  wire          bc_n     = (in_sof | bc_q) & (in_data == 8'hFF);
  wire [31:0]   crc_n    = crc_step(in_sof ? 32'hFFFF_FFFF : crc_q, in_data);
  wire          last     = take & (idx == LAST_IDX);
  wire          short_end = take & in_eof & ~last;
  wire          hash_hit = hash_all[crc_n[31:26]];
  wire          full_acc = cfg_promisc | ex_n | bc_n | (cfg_hash_en & hash_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      ex_q       <= 1'b0;
      bc_q       <= 1'b0;
      crc_q      <= 32'hFFFF_FFFF;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= (last | short_end) & cfg_rx_en;
      dec_accept <= last & cfg_rx_en & full_acc;
      if (take) begin
        ex_q     <= ex_n;
        bc_q     <= bc_n;
        crc_q    <= crc_n;
        cnt_q    <= idx + 1'b1;
        active_q <= ~(last | in_eof);
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic in_eof,
  input logic cfg_rx_en,
  input logic cfg_promisc,
  input logic dec_valid,
  input logic dec_accept
);
  p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(cfg_rx_en));

  p_promisc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(cfg_promisc) && !$past(in_eof)) |-> dec_accept);

  p_from_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

  p_tiny_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(in_valid && in_sof && in_eof)) |-> !dec_accept);

  p_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc),
  .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic cfg_rx_en = 1'b1, cfg_promisc = 1'b0, cfg_hash_en = 1'b0;
  logic [15:0] sta_w0 = 16'h0A1B, sta_w1 = 16'h2C3D, sta_w2 = 16'h4E5F;
  logic [15:0] hash_w0 = '0, hash_w1 = '0, hash_w2 = '0, hash_w3 = '0;
  logic dec_valid, dec_accept;

  int checks = 0, fails = 0;
  int strobe_cnt = 0;
  logic last_acc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .cfg_rx_en(cfg_rx_en),
    .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
    .sta_w0(sta_w0), .sta_w1(sta_w1), .sta_w2(sta_w2),
    .hash_w0(hash_w0), .hash_w1(hash_w1), .hash_w2(hash_w2), .hash_w3(hash_w3),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always @(posedge clk) if (dec_valid) begin
    strobe_cnt <= strobe_cnt + 1;
    last_acc   <= dec_accept;
  end

  // dest[51:4], promisc[3], hash_en[2], table all ones[1], expected accept[0]
  localparam logic [51:0] VEC [9] = '{
    {48'h0A1B2C3D4E5F, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 exact
    {48'h0A1B2C3D4E5E, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 last byte differs
    {48'h1B0A3D2C5F4E, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 swapped bytes
    {48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 broadcast
    {48'hFFFFFFFFFFFE, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 near broadcast
    {48'h0123456789AB, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 promiscuous
    {48'h0123456789AB, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 full table
    {48'h0123456789AB, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 empty table
    {48'h0123456789AB, 1'b0, 1'b0, 1'b1, 1'b0}   // R6 hash off
  };

  function automatic logic [31:0] ref_crc(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'h0, d[47-8*i -: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_table(input logic [63:0] t);
    {hash_w3, hash_w2, hash_w1, hash_w0} = t;
  endtask

  task automatic frame(input logic [47:0] d, input int n, input bit eof_last,
                       input bit with_sof, output int strobes, output bit acc,
                       output bit at7);
    int c0 = strobe_cnt;
    at7 = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 6) at7 = dec_valid;
      in_valid = 1'b1;
      in_sof   = with_sof && (i == 0);
      in_eof   = eof_last && (i == n - 1);
      in_data  = (i < 6) ? d[47-8*i -: 8] : 8'h55;
    end
    @(negedge clk);
    if (n == 6) at7 = dec_valid;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    strobes = strobe_cnt - c0;
    acc = last_acc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s; bit a, t;
    logic [47:0] md;
    logic [5:0] hidx;
    repeat (3) @(negedge clk);
    chk("R10 dec_valid in reset", dec_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dec_valid after reset", dec_valid, 0);
    frame(48'h0A1B2C3D4E5F, 8, 1'b1, 1'b0, s, a, t);
    chk("R10 no strobe without sof", s, 0);

    foreach (VEC[k]) begin
      cfg_promisc = VEC[k][3];
      cfg_hash_en = VEC[k][2];
      set_table(VEC[k][1] ? {64{1'b1}} : 64'h0);
      frame(VEC[k][51:4], 10, 1'b1, 1'b1, s, a, t);
      chk($sformatf("R7 one strobe vec%0d", k), s, 1);
      chk($sformatf("R2-R6 accept vec%0d", k), a, VEC[k][0]);
    end
    cfg_promisc = 1'b0; cfg_hash_en = 1'b0; set_table(64'h0);

    // R7 timing: strobe present one cycle after the sixth byte
    frame(48'h0A1B2C3D4E5F, 9, 1'b1, 1'b1, s, a, t);
    chk("R7 strobe cycle after sixth byte", t, 1);
    chk("R7 single strobe long frame", s, 1);

    // R5 single bin selection
    md = 48'h01005E000001;
    hidx = ref_crc(md)[31:26];
    cfg_hash_en = 1'b1;
    set_table(64'h1 << hidx);
    frame(md, 8, 1'b1, 1'b1, s, a, t);
    chk("R5 selected bin set", a, 1);
    set_table(~(64'h1 << hidx));
    frame(md, 8, 1'b1, 1'b1, s, a, t);
    chk("R5 only selected bin clear", a, 0);
    chk("R5 strobe", s, 1);
    cfg_hash_en = 1'b0; set_table(64'h0);

    // R1 receive disabled
    cfg_rx_en = 1'b0;
    frame(48'hFFFFFFFFFFFF, 8, 1'b1, 1'b1, s, a, t);
    chk("R1 no strobe when disabled", s, 0);
    frame(48'hFFFFFFFFFFFF, 3, 1'b1, 1'b1, s, a, t);
    chk("R1 no strobe short when disabled", s, 0);
    cfg_rx_en = 1'b1;

    // R8 short frames, even in promiscuous mode
    cfg_promisc = 1'b1;
    frame(48'h0A1B2C3D4E5F, 3, 1'b1, 1'b1, s, a, t);
    chk("R8 short strobe count", s, 1);
    chk("R8 short rejected", a, 0);
    frame(48'hFFFFFFFFFFFF, 1, 1'b1, 1'b1, s, a, t);
    chk("R8 one-byte strobe count", s, 1);
    chk("R8 one-byte rejected", a, 0);
    cfg_promisc = 1'b0;

    // R9 eof on sixth byte: full decision
    frame(48'h0A1B2C3D4E5F, 6, 1'b1, 1'b1, s, a, t);
    chk("R9 six-byte strobe count", s, 1);
    chk("R9 six-byte accepted", a, 1);
    chk("R9 strobe timing", t, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule